// File: doc/BRIEF.md
# Associative Grid-Bus Message Router

This block is a message switching fabric for a fixed number of sites. It is laid out as a grid of buses. Each site drives a row bus of its own that carries only what it sends, and it listens on a column bus of its own that carries only what is delivered to it. A message travels along its sender's row and then turns onto one or more columns at the crossings. Each crossing decides from a small associative table whether to pass the message onto its column. The table is keyed on the address of the object the message is aimed at, not on a site number. Moving an object from one site to another therefore only needs a table rewrite, and the senders do not change.

A sender offers a message with an object address, a routing mode and a payload. It holds the message on its port until the fabric signals completion. Unicast sends to the lowest-numbered column whose crossing recognises the address. Multicast sends to every such column. Broadcast sends to all columns and ignores the tables. A sender never competes for its own row, so contention exists only where several rows want the same column in the same cycle. Each column settles this with its own round-robin arbiter. Every column ends in a one-entry output register with a valid/ready handshake toward the receiving site.

Top module: `grid_bus_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every rx_valid is low. tx_ready is never high for a sender whose tx_valid is low.
- R2: Table port. With tbl_we high and tbl_inval low, tbl_addr is stored in the crossing (tbl_row, tbl_col) if it is absent and a free entry exists. A write into a full table is ignored. With tbl_inval high, the address is removed from that crossing. A crossing whose table lacks the address does not pass the message.
- R3: Mode 2'b00 (unicast) delivers exactly one copy, on the lowest-numbered column whose crossing on the sender's row holds the address.
- R4: Mode 2'b01 (multicast) delivers exactly one copy on every column whose crossing on the sender's row holds the address.
- R5: Modes 2'b10 and 2'b11 (broadcast) deliver one copy on every column, including the sender's own, whatever the tables hold.
- R6: A message with no target column completes in the cycle it is offered (tx_ready high) and nothing is delivered.
- R7: Each column grants among the competing rows in round-robin order. The search starts at the row after the one it last granted; after reset the search starts at row 1.
- R8: While rx_valid is high and rx_ready is low, the column output holds its address, data and source. No new message is granted onto that column.
- R9: A multi-target message completes (tx_ready high) only in the cycle its last outstanding column is granted. Columns that were already served get no second copy.
- R10: Messages from one sender to one receiver arrive in the order they were sent.
- R11: A message granted at a clock edge is shown on rx_valid, rx_addr and rx_data after that edge. rx_src carries the sending site's number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | NS | Per-sender message offered |
| tx_ready | output | NS | Per-sender message complete this cycle |
| tx_addr | input | NS*AW | Per-sender object address |
| tx_mode | input | NS*2 | Per-sender routing mode (00 unicast, 01 multicast, 1x broadcast) |
| tx_data | input | NS*PW | Per-sender payload |
| rx_valid | output | NS | Per-receiver message present |
| rx_ready | input | NS | Per-receiver consume |
| rx_addr | output | NS*AW | Per-receiver object address |
| rx_data | output | NS*PW | Per-receiver payload |
| rx_src | output | NS*SW | Per-receiver sender number |
| tbl_we | input | 1 | Table update strobe |
| tbl_inval | input | 1 | Update removes instead of stores |
| tbl_row | input | SW | Row (sender) of the crossing to update |
| tbl_col | input | SW | Column (receiver) of the crossing to update |
| tbl_addr | input | AW | Object address to store or remove |

## Verification
A table of single-sender messages covers each mode on addresses that hit one crossing, several crossings or none. This separates the lowest-hit choice of unicast from the all-hits fan-out of multicast, and table-driven delivery from broadcast. Table edits are checked by re-sending after an invalidate and after a write into a full table. Three rows contending for one column expose the rotation order. A stalled receiver shows hold-and-order behaviour. A multicast with one blocked target shows that a served column is not fed twice and that completion waits for the last grant.

// File: rtl/grid_bus_pkg.sv
package grid_bus_pkg;

    typedef enum logic [1:0] {
        MODE_UNI   = 2'b00,
        MODE_MULTI = 2'b01,
        MODE_BC0   = 2'b10,
        MODE_BC1   = 2'b11
    } route_mode_e;

    function automatic logic is_broadcast(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/xbar_cam.sv
module xbar_cam #(
    parameter int AW = 8,
    parameter int TE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          hit,
    input  logic          upd_en,
    input  logic          upd_inval,
    input  logic [AW-1:0] upd_addr
);

    typedef struct packed {
        logic [TE-1:0]         vld;
        logic [TE-1:0][AW-1:0] tag;
    } cam_t;

    cam_t          st_d, st_q;
    logic [TE-1:0] lk_match;
    logic [TE-1:0] up_match;
    logic          slot_taken;

    always_comb begin
        st_d       = st_q;
        slot_taken = 1'b0;
        for (int e = 0; e < TE; e++) begin
            lk_match[e] = st_q.vld[e] && (st_q.tag[e] == lk_addr);
            up_match[e] = st_q.vld[e] && (st_q.tag[e] == upd_addr);
        end
        if (upd_en) begin
            if (upd_inval) begin
                st_d.vld = st_q.vld & ~up_match;
            end else if (up_match == '0) begin
                for (int e = 0; e < TE; e++) begin
                    if (!slot_taken && !st_q.vld[e]) begin
                        st_d.vld[e] = 1'b1;
                        st_d.tag[e] = upd_addr;
                        slot_taken  = 1'b1;
                    end
                end
            end
        end
    end

    assign hit = |lk_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/col_arbiter.sv
module col_arbiter #(
    parameter int NS = 4,
    localparam int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] req,
    input  logic          en,
    output logic [NS-1:0] gnt
);

    logic [SW-1:0] ptr_d, ptr_q;
    logic          taken;

    always_comb begin
        gnt   = '0;
        ptr_d = ptr_q;
        taken = 1'b0;
        for (int i = 1; i <= NS; i++) begin
            if (en && !taken && req[(int'(ptr_q) + i) % NS]) begin
                gnt[(int'(ptr_q) + i) % NS] = 1'b1;
                ptr_d = SW'((int'(ptr_q) + i) % NS);
                taken = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/grid_bus_router.sv
module grid_bus_router
    import grid_bus_pkg::*;
#(
    parameter int NS = 4,
    parameter int AW = 8,
    parameter int PW = 16,
    parameter int TE = 4,
    localparam int SW = $clog2(NS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NS-1:0]    tx_valid,
    output logic [NS-1:0]    tx_ready,
    input  logic [NS*AW-1:0] tx_addr,
    input  logic [NS*2-1:0]  tx_mode,
    input  logic [NS*PW-1:0] tx_data,
    output logic [NS-1:0]    rx_valid,
    input  logic [NS-1:0]    rx_ready,
    output logic [NS*AW-1:0] rx_addr,
    output logic [NS*PW-1:0] rx_data,
    output logic [NS*SW-1:0] rx_src,
    input  logic           tbl_we,
    input  logic           tbl_inval,
    input  logic [SW-1:0]  tbl_row,
    input  logic [SW-1:0]  tbl_col,
    input  logic [AW-1:0]  tbl_addr
);

    typedef struct packed {
        logic [NS-1:0][NS-1:0] done;   // [row][col] already served
        logic [NS-1:0]         vld;
        logic [NS-1:0][AW-1:0] addr;
        logic [NS-1:0][PW-1:0] data;
        logic [NS-1:0][SW-1:0] src;
    } fab_t;

    fab_t                  st_d, st_q;
    logic [NS-1:0][NS-1:0] hit;    // [row][col]
    logic [NS-1:0][NS-1:0] tgt;    // [row][col]
    logic [NS-1:0][NS-1:0] creq;   // [col][row]
    logic [NS-1:0][NS-1:0] cgnt;   // [col][row]
    logic [NS-1:0][NS-1:0] dlv;    // [row][col]
    logic [NS-1:0]         col_free;
    logic [NS-1:0]         fin;

    // crossing tables
    for (genvar r = 0; r < NS; r++) begin : g_row
        for (genvar c = 0; c < NS; c++) begin : g_col
            xbar_cam #(.AW(AW), .TE(TE)) u_cam (
                .clk       (clk),
                .rst_n     (rst_n),
                .lk_addr   (tx_addr[r*AW +: AW]),
                .hit       (hit[r][c]),
                .upd_en    (tbl_we && (tbl_row == SW'(r)) && (tbl_col == SW'(c))),
                .upd_inval (tbl_inval),
                .upd_addr  (tbl_addr)
            );
        end
    end

    // target columns per sender
    always_comb begin
        for (int r = 0; r < NS; r++) begin
            if (is_broadcast(tx_mode[r*2 +: 2])) begin
                tgt[r] = '1;
            end else if (tx_mode[r*2 +: 2] == MODE_MULTI) begin
                tgt[r] = hit[r];
            end else begin
                tgt[r] = hit[r] & (~hit[r] + {{(NS-1){1'b0}}, 1'b1});
            end
        end
    end

    // column requests and free flags
    always_comb begin
        for (int c = 0; c < NS; c++) begin
            col_free[c] = !st_q.vld[c] || rx_ready[c];
            for (int r = 0; r < NS; r++) begin
                creq[c][r] = tx_valid[r] && tgt[r][c] && !st_q.done[r][c];
            end
        end
    end

    for (genvar c = 0; c < NS; c++) begin : g_arb
        col_arbiter #(.NS(NS)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (creq[c]),
            .en    (col_free[c]),
            .gnt   (cgnt[c])
        );
    end

    // next state
    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NS; c++) begin
            if (rx_ready[c]) begin
                st_d.vld[c] = 1'b0;
            end
            for (int r = 0; r < NS; r++) begin
                if (cgnt[c][r]) begin
                    st_d.vld[c]  = 1'b1;
                    st_d.addr[c] = tx_addr[r*AW +: AW];
                    st_d.data[c] = tx_data[r*PW +: PW];
                    st_d.src[c]  = SW'(r);
                end
            end
        end
        for (int r = 0; r < NS; r++) begin
            for (int c = 0; c < NS; c++) begin
                dlv[r][c] = st_q.done[r][c] || cgnt[c][r];
            end
            fin[r]       = ((tgt[r] & ~dlv[r]) == '0);
            tx_ready[r]  = tx_valid[r] && fin[r];
            st_d.done[r] = (tx_valid[r] && !fin[r]) ? dlv[r] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NS; c++) begin : g_out
        assign rx_addr[c*AW +: AW] = st_q.addr[c];
        assign rx_data[c*PW +: PW] = st_q.data[c];
        assign rx_src[c*SW +: SW]  = st_q.src[c];
    end
    assign rx_valid = st_q.vld;

endmodule

// File: rtl/grid_bus_router_chk.sv
module grid_bus_router_chk #(
    parameter int NS = 4,
    parameter int AW = 8,
    parameter int PW = 16,
    localparam int SW = $clog2(NS)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NS-1:0]    tx_valid,
    input logic [NS-1:0]    tx_ready,
    input logic [NS-1:0]    rx_valid,
    input logic [NS-1:0]    rx_ready,
    input logic [NS*AW-1:0] rx_addr,
    input logic [NS*PW-1:0] rx_data,
    input logic [NS*SW-1:0] rx_src
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> rx_valid == '0);

    for (genvar i = 0; i < NS; i++) begin : g_site
        p_ready_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
            tx_ready[i] |-> tx_valid[i]);

        p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[i] && !rx_ready[i]) |=>
                (rx_valid[i] && $stable(rx_data[i*PW +: PW]) &&
                 $stable(rx_addr[i*AW +: AW]) && $stable(rx_src[i*SW +: SW])));

        p_source_was_offering_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[i] && (!$past(rx_valid[i]) || $past(rx_ready[i]))) |->
                ((($past(tx_valid) >> rx_src[i*SW +: SW]) & NS'(1)) != '0));
    end

endmodule

bind grid_bus_router grid_bus_router_chk #(.NS(NS), .AW(AW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_addr  (rx_addr),
    .rx_data  (rx_data),
    .rx_src   (rx_src)
);

// File: tb/grid_bus_router_tb.sv
`timescale 1ns/1ps
module grid_bus_router_tb;

    localparam int NS = 4;
    localparam int AW = 8;
    localparam int PW = 16;
    localparam int SW = 2;
    localparam int NV = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    tx_valid = '0;
    logic [NS-1:0]    tx_ready;
    logic [NS*AW-1:0] tx_addr = '0;
    logic [NS*2-1:0]  tx_mode = '0;
    logic [NS*PW-1:0] tx_data = '0;
    logic [NS-1:0]    rx_valid;
    logic [NS-1:0]    rx_ready = '1;
    logic [NS*AW-1:0] rx_addr;
    logic [NS*PW-1:0] rx_data;
    logic [NS*SW-1:0] rx_src;
    logic             tbl_we = 1'b0;
    logic             tbl_inval = 1'b0;
    logic [SW-1:0]    tbl_row = '0;
    logic [SW-1:0]    tbl_col = '0;
    logic [AW-1:0]    tbl_addr = '0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    grid_bus_router #(.NS(NS), .AW(AW), .PW(PW), .TE(4)) u_dut (.*);

    // {sender[1:0], mode[1:0], addr[7:0], data[15:0], expected column mask[3:0]}
    localparam logic [31:0] VEC [NV] = '{
        {2'd0, 2'b00, 8'h11, 16'hA001, 4'b0010},
        {2'd0, 2'b01, 8'h11, 16'hA002, 4'b0110},
        {2'd0, 2'b10, 8'h99, 16'hA003, 4'b1111},
        {2'd0, 2'b00, 8'h22, 16'hA004, 4'b1000},
        {2'd1, 2'b00, 8'h33, 16'hA005, 4'b0001},
        {2'd1, 2'b01, 8'h11, 16'hA006, 4'b0000},
        {2'd2, 2'b01, 8'h44, 16'hA007, 4'b1001},
        {2'd2, 2'b00, 8'h44, 16'hA008, 4'b0001},
        {2'd3, 2'b11, 8'h77, 16'hA009, 4'b1111}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tbl(input int row, input int col, input logic [AW-1:0] a, input logic inv);
        @(negedge clk);
        tbl_we = 1'b1; tbl_inval = inv;
        tbl_row = SW'(row); tbl_col = SW'(col); tbl_addr = a;
        @(negedge clk);
        tbl_we = 1'b0; tbl_inval = 1'b0;
    endtask

    task automatic offer(input int s, input logic [1:0] m, input logic [AW-1:0] a, input logic [PW-1:0] d);
        tx_valid[s] = 1'b1;
        tx_mode[s*2 +: 2] = m;
        tx_addr[s*AW +: AW] = a;
        tx_data[s*PW +: PW] = d;
    endtask

    // one isolated message, checked for completion and per-column delivery
    task automatic single(input int s, input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [PW-1:0] d, input logic [NS-1:0] mask, input string req);
        @(negedge clk);
        offer(s, m, a, d);
        #1 chk(tx_ready[s] == 1'b1, req, int'(tx_ready), 1 << s);
        @(negedge clk);
        tx_valid = '0;
        #1 chk(rx_valid == mask, req, int'(rx_valid), int'(mask));
        for (int c = 0; c < NS; c++) begin
            if (mask[c]) begin
                chk(rx_data[c*PW +: PW] == d, req, int'(rx_data[c*PW +: PW]), int'(d));
                chk(rx_addr[c*AW +: AW] == a, req, int'(rx_addr[c*AW +: AW]), int'(a));
                chk(rx_src[c*SW +: SW] == SW'(s), "R11", int'(rx_src[c*SW +: SW]), s);
            end
        end
        @(negedge clk);
        #1 chk(rx_valid == '0, req, int'(rx_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rr_order [3] = '{1, 2, 0};
        // R1 reset state
        repeat (3) @(negedge clk);
        #1 chk(rx_valid == '0, "R1", int'(rx_valid), 0);
        chk(tx_ready == '0, "R1", int'(tx_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(rx_valid == '0, "R1", int'(rx_valid), 0);

        // R2 table contents
        tbl(0, 1, 8'h11, 1'b0);
        tbl(0, 2, 8'h11, 1'b0);
        tbl(0, 3, 8'h22, 1'b0);
        tbl(1, 0, 8'h33, 1'b0);
        tbl(2, 3, 8'h44, 1'b0);
        tbl(2, 0, 8'h44, 1'b0);

        // table-driven vectors: R3 unicast, R4 multicast, R5 broadcast, R6 no target
        for (int v = 0; v < NV; v++) begin
            string tag;
            if (VEC[v][3:0] == 4'b0000)  tag = "R6";
            else if (VEC[v][29])         tag = "R5";
            else if (VEC[v][28])         tag = "R4";
            else                         tag = "R3";
            single(int'(VEC[v][31:30]), VEC[v][29:28], VEC[v][27:20], VEC[v][19:4], VEC[v][3:0], tag);
        end

        // R2 invalidate: unicast moves to next hitting column
        tbl(0, 1, 8'h11, 1'b1);
        single(0, 2'b00, 8'h11, 16'hB100, 4'b0100, "R2");

        // R2 full table ignores a fifth address
        tbl(3, 0, 8'hA0, 1'b0);
        tbl(3, 0, 8'hA1, 1'b0);
        tbl(3, 0, 8'hA2, 1'b0);
        tbl(3, 0, 8'hA3, 1'b0);
        tbl(3, 0, 8'hA4, 1'b0);
        single(3, 2'b01, 8'hA4, 16'hB200, 4'b0000, "R2");
        single(3, 2'b01, 8'hA3, 16'hB201, 4'b0001, "R2");

        // R7 round robin on column 2 (last granted row 0)
        tbl(0, 2, 8'h55, 1'b0);
        tbl(1, 2, 8'h55, 1'b0);
        tbl(2, 2, 8'h55, 1'b0);
        @(negedge clk);
        offer(0, 2'b00, 8'h55, 16'hC100);
        offer(1, 2'b00, 8'h55, 16'hC101);
        offer(2, 2'b00, 8'h55, 16'hC102);
        #1 chk(tx_ready == 4'b0010, "R7", int'(tx_ready), 2);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 chk(rx_valid[2] && rx_src[2*SW +: SW] == SW'(rr_order[k]), "R7",
                   int'(rx_src[2*SW +: SW]), rr_order[k]);
            tx_valid[rr_order[k]] = 1'b0;
            #1;
            if (k < 2) chk(tx_ready == NS'(1 << rr_order[k+1]), "R7", int'(tx_ready), 1 << rr_order[k+1]);
        end
        @(negedge clk);

        // R8 stall hold, R10 order
        rx_ready[0] = 1'b0;
        offer(1, 2'b00, 8'h33, 16'hD001);
        #1 chk(tx_ready[1] == 1'b1, "R10", int'(tx_ready), 2);
        @(negedge clk);
        tx_data[1*PW +: PW] = 16'hD002;
        #1 chk(rx_valid[0] && rx_data[0 +: PW] == 16'hD001, "R11", int'(rx_data[0 +: PW]), 16'hD001);
        chk(tx_ready[1] == 1'b0, "R8", int'(tx_ready), 0);
        repeat (3) begin
            @(negedge clk);
            #1 chk(rx_valid[0] && rx_data[0 +: PW] == 16'hD001, "R8", int'(rx_data[0 +: PW]), 16'hD001);
        end
        rx_ready[0] = 1'b1;
        #1 chk(tx_ready[1] == 1'b1, "R8", int'(tx_ready), 2);
        @(negedge clk);
        tx_valid = '0;
        #1 chk(rx_valid[0] && rx_data[0 +: PW] == 16'hD002, "R10", int'(rx_data[0 +: PW]), 16'hD002);
        @(negedge clk);
        #1 chk(rx_valid == '0, "R10", int'(rx_valid), 0);

        // R9 partial multicast: column 2 blocked
        tbl(0, 1, 8'h11, 1'b0);
        tbl(2, 2, 8'h66, 1'b0);
        @(negedge clk);
        rx_ready[2] = 1'b0;
        offer(2, 2'b00, 8'h66, 16'hE002);
        #1 chk(tx_ready[2] == 1'b1, "R9", int'(tx_ready), 4);
        @(negedge clk);
        tx_valid = '0;
        offer(0, 2'b01, 8'h11, 16'hE011);
        #1 chk(tx_ready[0] == 1'b0, "R9", int'(tx_ready), 0);
        @(negedge clk);
        #1 chk(rx_valid[1] && rx_data[1*PW +: PW] == 16'hE011, "R9", int'(rx_data[1*PW +: PW]), 16'hE011);
        chk(rx_valid[2] && rx_src[2*SW +: SW] == 2'd2, "R8", int'(rx_src[2*SW +: SW]), 2);
        @(negedge clk);
        #1 chk(rx_valid[1] == 1'b0, "R9", int'(rx_valid), 0);
        chk(tx_ready[0] == 1'b0, "R9", int'(tx_ready), 0);
        rx_ready[2] = 1'b1;
        #1 chk(tx_ready[0] == 1'b1, "R9", int'(tx_ready), 1);
        @(negedge clk);
        tx_valid = '0;
        #1 chk(rx_valid[2] && rx_src[2*SW +: SW] == 2'd0 && rx_data[2*PW +: PW] == 16'hE011, "R9",
               int'(rx_data[2*PW +: PW]), 16'hE011);
        chk(rx_valid[1] == 1'b0, "R9", int'(rx_valid), 4);

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule